// File: doc/BRIEF.md
# Folded Restoring Integer Divider

The block divides a 32-bit unsigned dividend by a 16-bit unsigned divisor. Both operands may change on every operation. It returns a 32-bit quotient and a 16-bit remainder. The work is restoring long division: each step shifts the partial remainder left, brings in the next dividend bit (most significant first) and makes a trial subtraction of the divisor. One quotient bit comes out of each step.

The compile-time parameter `II` is the initiation interval. It must be one of 1, 2, 4, 8, 16 or 32. The block builds `32/II` step stages, and each stage is reused for `II` consecutive steps on one operation. A small `II` gives one accepted operation per clock at the cost of many stages. A large `II` needs far fewer stages and only lowers the accept rate. The latency from accept to result is the same for every `II`.

Operands enter through a valid/ready handshake. A single `out_valid_o` flag marks each result, and results leave in the order their operations were accepted.

Top module: `divu_pipe`

## Requirements
- R1: For a non-zero divisor, `quotient_o` equals floor(dividend/divisor) and `remainder_o` equals dividend mod divisor, with `div_by_zero_o` low.
- R2: For a zero divisor, `quotient_o` is 32'hFFFF_FFFF, `remainder_o` equals dividend bits [15:0], and `div_by_zero_o` is high in the same cycle as `out_valid_o`.
- R3: `out_valid_o` for an operation is high in the cycle that follows the 33rd rising edge after the edge that accepted it, for every value of `II`.
- R4: `in_ready_o` is constantly high when `II` is 1. For larger `II`, it is low for exactly `II-1` cycles after each accepted operation and high otherwise.
- R5: An operand presented while `in_ready_o` is low is ignored: it produces no result and does not disturb any result in flight.
- R6: Every accepted operation yields exactly one `out_valid_o` cycle, and results leave in accept order.
- R7: While `rst_ni` is low and after its release, `out_valid_o` is low and `in_ready_o` is high until the first operation is accepted.
- R8: At the maximum accept rate (one operation every `II` cycles, sustained), every result is correct and on time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands are presented |
| in_ready_o | output | 1 | Block accepts operands at this edge |
| dividend_i | input | 32 | Unsigned dividend |
| divisor_i | input | 16 | Unsigned divisor |
| out_valid_o | output | 1 | Result is presented in this cycle |
| quotient_o | output | 32 | Unsigned quotient |
| remainder_o | output | 16 | Unsigned remainder |
| div_by_zero_o | output | 1 | Divisor of the presented result was zero |

## Verification
Every accepted operation has one fixed due cycle. The due cycle is 34 falling edges after the falling edge at which the bench drove the operands, which is 33 rising edges after the accepting edge. The bench records the due cycle along with the expected quotient, remainder and flag in an in-order queue. At each falling edge it compares `out_valid_o` against the head entry's due cycle, so a late, early, missing or extra result fails as a latency or ordering error rather than slipping by. `in_ready_o` is compared every cycle against a gap counter kept in the bench. Operands offered while that counter is non-zero never enter the queue, so any result they might produce shows up as an unexpected `out_valid_o`.

// File: rtl/divu_pkg.sv
package divu_pkg;
  localparam int unsigned DVD_W = 32;
  localparam int unsigned DVS_W = 16;

  typedef struct packed {
    logic [DVS_W-1:0] rem;  // partial remainder
    logic [DVD_W-1:0] shf;  // dividend bits out at MSB, quotient bits in at LSB
    logic [DVS_W-1:0] dvs;
    logic             dz;
  } divu_op_t;

  // one restoring step; trial is two bits wider than rem so a zero divisor never goes negative
  function automatic divu_op_t divu_step(input divu_op_t a);
    logic [DVS_W+1:0] trial;
    logic             qbit;
    divu_op_t         r;
    trial = {1'b0, a.rem, a.shf[DVD_W-1]} - {2'b00, a.dvs};
    qbit  = ~trial[DVS_W+1];
    r     = a;
    r.rem = qbit ? trial[DVS_W-1:0] : {a.rem[DVS_W-2:0], a.shf[DVD_W-1]};
    r.shf = {a.shf[DVD_W-2:0], qbit};
    return r;
  endfunction
endpackage

// File: rtl/divu_issue_ctrl.sv
module divu_issue_ctrl #(
  parameter int unsigned II = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic ready_o
);
  if (II == 1) begin : g_full_rate
    assign ready_o = 1'b1;
  end else begin : g_gapped
    localparam int unsigned GW = $clog2(II);
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          gap_q <= '0;
      else if (fire_i)      gap_q <= GW'(II - 1);
      else if (gap_q != 0)  gap_q <= gap_q - 1'b1;
    end

    assign ready_o = (gap_q == '0);

    assert_gap_after_fire_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_i |=> !ready_o);
    assert_gap_closes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ready_o && gap_q == GW'(1)) |=> ready_o);
  end
endmodule

// File: rtl/divu_fold_stage.sv
module divu_fold_stage
  import divu_pkg::*;
#(
  parameter int unsigned II = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  divu_op_t op_i,
  output logic     done_o,
  output divu_op_t op_o
);
  localparam int unsigned CW = $clog2(II + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  divu_op_t      op_q;
  divu_op_t      step_in;
  logic          step_en;

  assign step_en = load_i | (busy_q & (cnt_q != CW'(II)));
  assign step_in = load_i ? op_i : op_q;

  // datapath: no reset needed
  always_ff @(posedge clk_i) begin
    if (step_en) op_q <= divu_step(step_in);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(1);
    end else if (busy_q && cnt_q == CW'(II)) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = busy_q && (cnt_q == CW'(II));
  assign op_o   = op_q;

  // a new operation may only arrive when the slot is empty or being vacated
  assert_no_overrun_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (!busy_q || done_o));
  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q >= CW'(1) && cnt_q <= CW'(II)));
endmodule

// File: rtl/divu_pipe.sv
module divu_pipe
  import divu_pkg::*;
#(
  parameter int unsigned II = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             out_valid_o,
  output logic [DVD_W-1:0] quotient_o,
  output logic [DVS_W-1:0] remainder_o,
  output logic             div_by_zero_o
);
  localparam int unsigned NSTG = DVD_W / II;

  if (DVD_W % II != 0) begin : g_bad_ii
    initial $error("II must divide the dividend width");
  end

  logic     fire;
  logic     in_vld_q;
  divu_op_t in_op_q;
  logic     out_vld_q;
  divu_op_t out_op_q;

  assign fire = in_valid_i & in_ready_o;

  divu_issue_ctrl #(.II(II)) u_issue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .ready_o (in_ready_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_vld_q <= 1'b0;
    else         in_vld_q <= fire;
  end

  always_ff @(posedge clk_i) begin
    if (fire) begin
      in_op_q.rem <= '0;
      in_op_q.shf <= dividend_i;
      in_op_q.dvs <= divisor_i;
      in_op_q.dz  <= (divisor_i == '0);
    end
  end

  logic     [NSTG-1:0] st_done;
  divu_op_t            st_op [NSTG];

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    logic     ld;
    divu_op_t src;
    if (k == 0) begin : g_head
      assign ld  = in_vld_q;
      assign src = in_op_q;
    end else begin : g_body
      assign ld  = st_done[k-1];
      assign src = st_op[k-1];
    end
    divu_fold_stage #(.II(II)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (ld),
      .op_i   (src),
      .done_o (st_done[k]),
      .op_o   (st_op[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_vld_q <= 1'b0;
    else         out_vld_q <= st_done[NSTG-1];
  end

  always_ff @(posedge clk_i) begin
    if (st_done[NSTG-1]) out_op_q <= st_op[NSTG-1];
  end

  assign out_valid_o   = out_vld_q;
  assign quotient_o    = out_op_q.shf;
  assign remainder_o   = out_op_q.rem;
  assign div_by_zero_o = out_op_q.dz;

  assert_zero_div_quot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && div_by_zero_o) |-> (quotient_o == '1));
  assert_rem_below_dvs_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !div_by_zero_o) |-> (remainder_o < out_op_q.dvs));
  assert_dz_matches_dvs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (div_by_zero_o == (out_op_q.dvs == '0)));

  if (II > 1) begin : g_pulse_chk
    assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |=> !out_valid_o);
  end
endmodule

// File: tb/divu_pipe_tb.sv
module divu_pipe_tb;
  localparam int unsigned II   = 4;
  localparam int          DUE  = 34;   // negedges from drive to result
  localparam int          NDIR = 10;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] dividend;
  logic [15:0] divisor;
  logic        out_valid;
  logic [31:0] quotient;
  logic [15:0] remainder;
  logic        dz;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  int gap   = 0;
  bit done  = 0;

  logic [31:0] q_a[$];
  logic [15:0] q_b[$];
  int          q_due[$];

  always #10 clk = ~clk;

  divu_pipe #(.II(II)) u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .in_valid_i    (in_valid),
    .in_ready_o    (in_ready),
    .dividend_i    (dividend),
    .divisor_i     (divisor),
    .out_valid_o   (out_valid),
    .quotient_o    (quotient),
    .remainder_o   (remainder),
    .div_by_zero_o (dz)
  );

  function automatic logic [31:0] dir_a(int i);
    case (i)
      0: return 32'd0;          1: return 32'hDEAD_BEEF;  2: return 32'h1234_5678;
      3: return 32'h89AB_CDEF;  4: return 32'd0;          5: return 32'hFFFF_FFFF;
      6: return 32'hFFFF_FFFF;  7: return 32'd12345;      8: return 32'd65535;
      default: return 32'd100;
    endcase
  endfunction

  function automatic logic [15:0] dir_b(int i);
    case (i)
      0: return 16'd5;     1: return 16'd1;      2: return 16'hFFFF;
      3: return 16'd0;     4: return 16'd0;      5: return 16'd1;
      6: return 16'hFFFF;  7: return 16'd12346;  8: return 16'd65535;
      default: return 16'd7;
    endcase
  endfunction

  function automatic logic [15:0] rnd_b();
    int unsigned s = $urandom % 8;
    if (s == 0) return 16'd0;
    if (s < 3)  return 16'($urandom % 16 + 1);
    return 16'($urandom);
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic monitor();
    check(in_ready == (gap == 0), "R4", "in_ready", 64'(in_ready), 64'(gap == 0));
    if (out_valid) begin
      if (q_due.size() == 0 || q_due[0] != cyc) begin
        // R3/R6: result outside its due cycle, or from an ignored operand (R5)
        check(1'b0, "R3/R5/R6", "unexpected out_valid", 64'(cyc),
              64'(q_due.size() ? q_due[0] : -1));
      end else begin
        logic [31:0] a = q_a.pop_front();
        logic [15:0] b = q_b.pop_front();
        logic [31:0] eq;
        logic [15:0] er;
        void'(q_due.pop_front());
        if (b == 0) begin
          eq = 32'hFFFF_FFFF; er = a[15:0];
          check(quotient == eq && remainder == er && dz, "R2", "zero divisor",
                {quotient, remainder, 15'd0, dz}, {eq, er, 16'd1});
        end else begin
          eq = a / 32'(b); er = 16'(a % 32'(b));
          check(quotient == eq && remainder == er && !dz, "R1/R8", "quotient/remainder",
                {quotient, remainder, 15'd0, dz}, {eq, er, 16'd0});
        end
      end
    end else if (q_due.size() != 0 && q_due[0] == cyc) begin
      check(1'b0, "R3", "missing out_valid", 64'd0, 64'd1);
      void'(q_a.pop_front()); void'(q_b.pop_front()); void'(q_due.pop_front());
    end
  endtask

  task automatic model();
    if (in_valid && gap == 0) begin
      q_a.push_back(dividend);
      q_b.push_back(divisor);
      q_due.push_back(cyc + DUE);
      gap = int'(II) - 1;
    end else if (gap > 0) begin
      gap--;
    end
  endtask

  initial begin
    int didx = 0;
    void'($urandom(32'd1234));
    rst_ni = 1'b0; in_valid = 1'b0; dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R7", "reset state", {out_valid, in_ready}, 2'b01);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R7", "after release", {out_valid, in_ready}, 2'b01);

    for (int c = 0; c < 900; c++) begin
      @(negedge clk); cyc++;
      monitor();
      if (didx < NDIR) begin
        // directed corners, held until accepted
        in_valid = 1'b1; dividend = dir_a(didx); divisor = dir_b(didx);
        if (gap == 0) didx++;
      end else if (c < 500) begin
        // R5/R8: valid held high, fresh operands every cycle
        in_valid = 1'b1; dividend = $urandom; divisor = rnd_b();
      end else begin
        in_valid = ($urandom % 2) == 0; dividend = $urandom; divisor = rnd_b();
      end
      model();
    end

    in_valid = 1'b0;
    repeat (DUE + 6) begin
      @(negedge clk); cyc++;
      monitor();
      model();
    end
    check(q_due.size() == 0, "R6", "results outstanding", 64'(q_due.size()), 64'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule